// File: doc/BRIEF.md
# Streaming MTIE Window Calculator

This block measures the wander of a clock from a stream of signed time-error samples. Software or an upstream phase detector picks a window of n samples and a block of N samples, then pulses a block start. Each accepted sample moves an n-sample window one step along. For every window position the block takes the largest sample minus the smallest sample, the peak-to-peak excursion, and it keeps the largest excursion seen so far. That running figure is the maximum time interval error, MTIE(n), over the samples received. Once the block has N samples it gives a done pulse and holds the result.

The sliding maximum and minimum come from two monotonic candidate queues, one for each. Each queue holds sample value and sample index. A queue entry leaves when its index drops out of the window, or when a newer sample makes it useless. Each queue is updated in a single cycle, so one sample can be taken on every clock.

Top module: `mtie_tracker`

## Requirements
- R1: For each window of n consecutive accepted samples, the excursion is its maximum minus its minimum. Once the block completes, `mtie` equals the largest excursion over all start positions 0..N-n.
- R2: While fewer than n samples of the current block have been accepted, `mtie` reads zero.
- R3: `done` is high for exactly one cycle. It appears on the clock edge that accepts the N-th sample of the block.
- R4: After `done`, `mtie` holds its final value until the next `start`. Samples offered in that time change nothing.
- R5: If, at `start`, n is zero, n exceeds N, or n exceeds the queue depth DEPTH (256 by default), `cfg_err` goes high. The block then keeps `mtie` at zero, accepts no samples and never pulses `done`.
- R6: With n = 1, the result is zero. With n = N, the result is the maximum minus the minimum over the whole block.
- R7: For a fixed block of data, the final MTIE never decreases as n grows.
- R8: Samples are 24-bit two's complement. The excursion is unsigned and 25 bits wide, so a swing from -8388608 to 8388607 reads 16777215.
- R9: Cycles with `smp_valid` low do not count as samples and leave `mtie` unchanged.
- R10: `start` samples `win_len` and `blk_len`, clears the result, and replaces any earlier error state. `start` has priority over a sample offered in the same cycle.
- R11: After each accepted sample, `mtie` equals the MTIE of the samples accepted so far in the block. The value is visible one clock edge after the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new block; samples the two lengths |
| smp_valid | input | 1 | Sample strobe |
| smp_value | input | 24 | Signed time-error sample |
| win_len | input | 16 | Window length n in samples |
| blk_len | input | 16 | Block length N in samples |
| mtie | output | 25 | Running maximum peak-to-peak excursion |
| done | output | 1 | One-cycle pulse after the N-th sample |
| cfg_err | output | 1 | Invalid window/block setting |

## Verification
A queue that keeps an entry too long, or drops one too early, gives a wrong window extreme. That error reaches `mtie` on the same edge as the sample that exposes it. The bench therefore compares `mtie` with a brute-force reference after every sample on short blocks, with a strictly falling ramp that fills the maximum queue to its full depth, and with a rising ramp for the minimum queue. A miscount of accepted samples appears as a misplaced `done`, or as a nonzero result before the window fills. The hold, error and n-sweep tests cover control state that the data tests do not reach.

// File: rtl/mtie_tracker.sv
module mtie_tracker #(
  parameter int SW    = 24,
  parameter int LW    = 16,
  parameter int DEPTH = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_value,
  input  logic [LW-1:0]        win_len,
  input  logic [LW-1:0]        blk_len,
  output logic [SW:0]          mtie,
  output logic                 done,
  output logic                 cfg_err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic signed [SW-1:0] qv [2][DEPTH];
  logic [LW-1:0]        qi [2][DEPTH];
  logic [CW-1:0]        qn [2];
  logic signed [SW-1:0] nv [2][DEPTH];
  logic [LW-1:0]        ni [2][DEPTH];
  logic [CW-1:0]        nn [2];
  logic [CW-1:0]        kc [2];
  logic                 sh [2];

  logic [LW-1:0] n_len, b_len, k;
  logic          active;
  logic [SW:0]   ex;
  logic          bad_cfg;

  always_comb begin
    for (int q = 0; q < 2; q++) begin
      kc[q] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (CW'(j) < qn[q] && ((q == 0) ? (qv[q][j] > smp_value) : (qv[q][j] < smp_value)))
          kc[q] = kc[q] + 1'b1;
      sh[q] = (qn[q] != '0) && ((k - qi[q][0]) >= n_len) && (kc[q] != '0);
      for (int j = 0; j < DEPTH; j++) begin
        if (CW'(j) + CW'(sh[q]) < kc[q]) begin
          nv[q][j] = qv[q][AW'(j + int'(sh[q]))];
          ni[q][j] = qi[q][AW'(j + int'(sh[q]))];
        end else begin
          nv[q][j] = smp_value;
          ni[q][j] = k;
        end
      end
      nn[q] = kc[q] + 1'b1 - CW'(sh[q]);
    end
  end

  assign ex = {nv[0][0][SW-1], nv[0][0]} - {nv[1][0][SW-1], nv[1][0]};
  assign bad_cfg = (win_len == '0) || (win_len > blk_len) || (32'(win_len) > DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_len   <= '0;
      b_len   <= '0;
      k       <= '0;
      active  <= 1'b0;
      mtie    <= '0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
      qn[0]   <= '0;
      qn[1]   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        n_len   <= win_len;
        b_len   <= blk_len;
        k       <= '0;
        mtie    <= '0;
        qn[0]   <= '0;
        qn[1]   <= '0;
        cfg_err <= bad_cfg;
        active  <= !bad_cfg;
      end else if (active && smp_valid) begin
        qv <= nv;
        qi <= ni;
        qn <= nn;
        k  <= k + 1'b1;
        if ((k + 1'b1) >= n_len && ex > mtie) mtie <= ex;
        if ((k + 1'b1) == b_len) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (qn[0] <= CW'(n_len) && qn[1] <= CW'(n_len)));  // R1
  AST_MAX_GE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && qn[0] != '0 && qn[1] != '0) |-> (qv[0][0] >= qv[1][0]));  // R1
  AST_EARLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (active && k < n_len) |-> (mtie == '0));  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R3
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(mtie));  // R4
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (mtie == '0 && !active && !done));  // R5
  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (mtie >= $past(mtie)));  // R11
endmodule

// File: tb/test_mtie_tracker.sv
module test_mtie_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [23:0] smp_value = '0;
  logic [15:0] win_len = '0;
  logic [15:0] blk_len = '0;
  logic [24:0] mtie;
  logic done, cfg_err;

  int n_checks = 0;
  int n_errs = 0;
  logic signed [23:0] dat [0:511];
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  mtie_tracker i_mtie_tracker (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
    .smp_value(smp_value), .win_len(win_len), .blk_len(blk_len),
    .mtie(mtie), .done(done), .cfg_err(cfg_err));

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_mtie(input int p, input int nw);
    longint best = 0;
    if (p < nw) return 0;
    for (int i = 0; i <= p - nw; i++) begin
      longint mx = longint'(dat[i]);
      longint mn = longint'(dat[i]);
      for (int j = i; j < i + nw; j++) begin
        if (longint'(dat[j]) > mx) mx = longint'(dat[j]);
        if (longint'(dat[j]) < mn) mn = longint'(dat[j]);
      end
      if (mx - mn > best) best = mx - mn;
    end
    return best;
  endfunction

  function automatic logic signed [23:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:7];
  endfunction

  task automatic begin_block(input int nw, input int nb);
    @(negedge clk);
    start = 1'b1; win_len = 16'(nw); blk_len = 16'(nb);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_block(input int nw, input int nb, input bit running, output longint fin);
    begin_block(nw, nb);
    chk("R10 err clear", longint'(cfg_err), 0);
    for (int i = 0; i < nb; i++) begin
      smp_valid = 1'b1; smp_value = dat[i];
      @(negedge clk);
      smp_valid = 1'b0;
      if (running) begin
        chk("R11 running mtie", longint'(mtie), ref_mtie(i + 1, nw));
        if (i + 1 < nw) chk("R2 early zero", longint'(mtie), 0);
      end
      if (i == nb - 1) chk("R3 done at last", longint'(done), 1);
      else if (running) chk("R3 no early done", longint'(done), 0);
      if (i % 5 == 3) begin
        @(negedge clk);
        if (running) chk("R9 idle no change", longint'(mtie), ref_mtie(i + 1, nw));
      end
    end
    @(negedge clk);
    chk("R3 done one cycle", longint'(done), 0);
    chk("R1 final mtie", longint'(mtie), ref_mtie(nb, nw));
    fin = longint'(mtie);
  endtask

  task automatic t_reset();
    chk("R10 reset mtie", longint'(mtie), 0);
    chk("R3 reset done", longint'(done), 0);
    chk("R5 reset err", longint'(cfg_err), 0);
  endtask

  task automatic t_short();
    longint f;
    for (int i = 0; i < 40; i++) dat[i] = 24'((i * 37) % 23 - 11);
    run_block(4, 40, 1'b1, f);
    for (int i = 0; i < 30; i++) dat[i] = rnd();
    run_block(7, 30, 1'b1, f);
  endtask

  task automatic t_hold();
    longint f;
    for (int i = 0; i < 12; i++) dat[i] = 24'(i);
    run_block(3, 12, 1'b1, f);
    chk("R1 ramp n3", f, 2);
    for (int i = 0; i < 6; i++) begin
      smp_valid = 1'b1; smp_value = (i % 2) ? 24'sd8000000 : -24'sd8000000;
      @(negedge clk);
      smp_valid = 1'b0;
      chk("R4 hold mtie", longint'(mtie), f);
      chk("R4 no done", longint'(done), 0);
    end
  endtask

  task automatic t_sweep();
    int lens[8] = '{1, 2, 3, 5, 8, 16, 32, 48};
    longint prev = 0;
    longint f;
    longint mx = -(64'sd1 << 40);
    longint mn = 64'sd1 << 40;
    for (int i = 0; i < 48; i++) begin
      dat[i] = rnd();
      if (longint'(dat[i]) > mx) mx = longint'(dat[i]);
      if (longint'(dat[i]) < mn) mn = longint'(dat[i]);
    end
    foreach (lens[t]) begin
      run_block(lens[t], 48, 1'b0, f);
      if (lens[t] == 1) chk("R6 n one zero", f, 0);
      if (lens[t] == 48) chk("R6 n full span", f, mx - mn);
      chk("R7 nondecreasing", longint'(f >= prev), 1);
      prev = f;
    end
  endtask

  task automatic t_extremes();
    longint f;
    for (int i = 0; i < 6; i++) dat[i] = (i % 2) ? -24'sd8388608 : 24'sd8388607;
    run_block(2, 6, 1'b1, f);
    chk("R8 full swing", f, 64'd16777215);
  endtask

  task automatic t_errors();
    int bad_n[3] = '{0, 9, 257};
    int bad_b[3] = '{8, 8, 300};
    longint f;
    foreach (bad_n[t]) begin
      begin_block(bad_n[t], bad_b[t]);
      chk("R5 err flag", longint'(cfg_err), 1);
      for (int i = 0; i < 10; i++) begin
        smp_valid = 1'b1; smp_value = (i % 2) ? 24'sd5000 : -24'sd5000;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R5 zero result", longint'(mtie), 0);
        chk("R5 no done", longint'(done), 0);
      end
    end
    for (int i = 0; i < 5; i++) dat[i] = 24'(i * 10);
    run_block(2, 5, 1'b1, f);
    chk("R10 recovered", f, 10);
    @(negedge clk);
    start = 1'b1; win_len = 16'd2; blk_len = 16'd4; smp_valid = 1'b1; smp_value = 24'sd9999;
    @(negedge clk);
    start = 1'b0; smp_valid = 1'b0;
    chk("R10 start clears", longint'(mtie), 0);
    for (int i = 0; i < 4; i++) begin
      smp_valid = 1'b1; smp_value = 24'(i);
      @(negedge clk);
      smp_valid = 1'b0;
    end
    chk("R10 start wins sample", longint'(done), 1);
    chk("R10 start wins value", longint'(mtie), 1);
  endtask

  task automatic t_deep();
    longint f;
    for (int i = 0; i < 300; i++) dat[i] = 24'(1000 - 3 * i);
    run_block(256, 300, 1'b0, f);
    chk("R1 falling depth", f, 765);
    for (int i = 0; i < 300; i++) dat[i] = 24'(5 * i - 700);
    run_block(256, 300, 1'b0, f);
    chk("R1 rising depth", f, 1275);
    for (int i = 0; i < 280; i++) dat[i] = rnd() >>> 4;
    run_block(200, 280, 1'b0, f);
  endtask

  initial begin
    #(20 * 200000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_hold();
    t_sweep();
    t_extremes();
    t_errors();
    t_deep();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule